// File: doc/BRIEF.md
# Staged Address/Data Register Memory Bridge

This block sits between a processing unit and a word-organised memory array. The array holds 2^AW locations of DW bits each, and an AW-bit address selects exactly one of them. The processor side presents a single command, either a load or a store, with an address and, for a store, a data word. The bridge then carries the command out as a fixed sequence of register-transfer steps. Each step goes through an address register and a data register, and the memory always sees its address and write data from those two registers.

A load first puts the address into the address register. It then raises a read strobe, and the word the memory returns is captured into the data register and presented to the processor. A store first puts the data word into the data register. One cycle later it puts the address into the address register, and only after that does it raise the write strobe. Each register-transfer step takes one clock cycle. The memory access step lasts until the memory side answers with a one-cycle ready pulse, so it can take any number of cycles. Only one command is in flight at a time. The processor sees a busy level and a one-cycle done pulse.

Top module: `mar_mdr_bridge`

## Requirements
- R1: While and after a synchronous active-low reset, busy, done, the read strobe and the write strobe are 0. The address register (mem_addr) and the data register (mem_wdata, rd_data) read 0.
- R2: A command is accepted only when cmd_valid is high at a clock edge while busy is low (cmd_we = 1 means store, 0 means load). busy goes high after that edge. Any command presented while busy is high is ignored: it causes no memory access, no done pulse and no memory change.
- R3: For a load, the address register takes cmd_addr at the accepting edge. mem_rd is high from the very next cycle, with mem_addr equal to that address.
- R4: For a store, the data register takes cmd_wdata at the accepting edge while the address register keeps its old value. The address register takes the address one edge later. mem_wr rises in the cycle after that, with the data register unchanged.
- R5: A strobe stays high until the cycle in which mem_ready is high, and drops after that edge. mem_addr and mem_wdata stay stable while a strobe waits.
- R6: At the edge where mem_ready meets mem_rd, the data register captures mem_rdata. In the next cycle done is high and rd_data shows that word. rd_data keeps it until the next command is accepted.
- R7: done is high for exactly one cycle per accepted command. busy stays high from acceptance through the done cycle and is low in the cycle after done.
- R8: Each command performs exactly one memory access, and it moves one whole word. A store changes only the addressed location.
- R9: When mem_ready arrives in the L-th cycle of the strobe (L ≥ 1), busy lasts L+1 cycles for a load and L+2 cycles for a store, with done in the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_we | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | AW | Word address of the command |
| cmd_wdata | input | DW | Store data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Loaded word, valid from done until the next command |
| mem_addr | output | AW | Address register contents to memory |
| mem_wdata | output | DW | Data register contents to memory |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_ready | input | 1 | One-cycle completion pulse from memory |
| mem_rdata | input | DW | Word returned by memory |

## Verification
Assertions check several properties on every cycle. A waiting strobe is held, and address and data stay frozen while it waits. Done is a single pulse that follows the ready edge, and on a load it carries the word that was presented at that edge. Each ready pulse ends the access. The write data is already settled when the write strobe rises. Other properties can only be shown by the bench scenarios, which sweep every address with a range of memory latencies. These are the exact busy length for each latency, the store step order as seen at the memory pins, the fact that commands issued while busy leave memory untouched, and the fact that each store changes one location only.

// File: rtl/mmb_pkg.sv
// Shared types for the staged address/data register memory bridge.
package mmb_pkg;
    // Micro-step of the bridge sequencer.
    typedef enum logic [2:0] {
        STEP_IDLE   = 3'd0,
        STEP_LD_ACC = 3'd1,
        STEP_ST_ADR = 3'd2,
        STEP_ST_ACC = 3'd3,
        STEP_FIN    = 3'd4
    } step_t;
endpackage

// File: rtl/mmb_ctrl.sv
// Sequencer of the bridge. Accepts one command while idle and steps through
// the load or store micro-sequence. It holds the memory strobe until ready
// and issues the register load enables for the datapath.
// Assumes mem_ready is a single-cycle pulse that comes only during a strobe.
module mmb_ctrl
    import mmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_we,
    input  logic mem_ready,
    output logic busy,
    output logic done,
    output logic mem_rd,
    output logic mem_wr,
    output logic ld_mar_cmd,
    output logic ld_mar_hold,
    output logic ld_hold,
    output logic ld_mdr_cmd,
    output logic ld_mdr_mem
);
    step_t step_q, step_d;
    logic  accept;

    // Command acceptance happens only in the idle step.
    assign accept = (step_q == STEP_IDLE) && cmd_valid;

    // Next-step selection for the load and store micro-sequences.
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            STEP_IDLE:   if (cmd_valid) step_d = cmd_we ? STEP_ST_ADR : STEP_LD_ACC;
            STEP_LD_ACC: if (mem_ready) step_d = STEP_FIN;
            STEP_ST_ADR: step_d = STEP_ST_ACC;
            STEP_ST_ACC: if (mem_ready) step_d = STEP_FIN;
            STEP_FIN:    step_d = STEP_IDLE;
            default:     step_d = STEP_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= STEP_IDLE;
        else        step_q <= step_d;
    end

    // Decoded strobes, status and register enables.
    always_comb begin
        mem_rd      = (step_q == STEP_LD_ACC);
        mem_wr      = (step_q == STEP_ST_ACC);
        done        = (step_q == STEP_FIN);
        busy        = (step_q != STEP_IDLE);
        ld_mar_cmd  = accept && !cmd_we;
        ld_hold     = accept && cmd_we;
        ld_mdr_cmd  = accept && cmd_we;
        ld_mar_hold = (step_q == STEP_ST_ADR);
        ld_mdr_mem  = mem_rd && mem_ready;
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy);
    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> mem_rd);
    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> mem_wr);
endmodule

// File: rtl/mmb_regs.sv
// Datapath of the bridge: address register, data register and the store
// address holding register. The memory sees only the address and data
// registers. Assumes at most one load enable per register in any cycle.
module mmb_regs #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ld_mar_cmd,
    input  logic          ld_mar_hold,
    input  logic          ld_hold,
    input  logic          ld_mdr_cmd,
    input  logic          ld_mdr_mem,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mdr
);
    logic [AW-1:0] hold_q;

    // Address register: direct for loads, from the holding register for stores.
    always_ff @(posedge clk) begin
        if (!rst_n)           mar <= '0;
        else if (ld_mar_cmd)  mar <= cmd_addr;
        else if (ld_mar_hold) mar <= hold_q;
    end

    // Holding register keeps the store address for the second step.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (ld_hold) hold_q <= cmd_addr;
    end

    // Data register: store data on acceptance, memory word on read ready.
    always_ff @(posedge clk) begin
        if (!rst_n)          mdr <= '0;
        else if (ld_mdr_cmd) mdr <= cmd_wdata;
        else if (ld_mdr_mem) mdr <= mem_rdata;
    end
endmodule

// File: rtl/mar_mdr_bridge.sv
// Top of the staged address/data register memory bridge. It connects the
// sequencer to the register datapath and exposes both registers to the memory.
// Assumes the memory holds mem_rdata valid in the cycle it pulses mem_ready.
module mar_mdr_bridge #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_we,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata
);
    logic ld_mar_cmd, ld_mar_hold, ld_hold, ld_mdr_cmd, ld_mdr_mem;
    logic [AW-1:0] mar;
    logic [DW-1:0] mdr;

    mmb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
        .mem_ready(mem_ready), .busy(busy), .done(done),
        .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ld_mar_cmd(ld_mar_cmd), .ld_mar_hold(ld_mar_hold), .ld_hold(ld_hold),
        .ld_mdr_cmd(ld_mdr_cmd), .ld_mdr_mem(ld_mdr_mem)
    );

    mmb_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .mem_rdata(mem_rdata), .ld_mar_cmd(ld_mar_cmd), .ld_mar_hold(ld_mar_hold),
        .ld_hold(ld_hold), .ld_mdr_cmd(ld_mdr_cmd), .ld_mdr_mem(ld_mdr_mem),
        .mar(mar), .mdr(mdr)
    );

    // Both registers face the memory; the data register also feeds the processor.
    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign rd_data   = mdr;

    // R6
    load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready) |=> (done && rd_data == $past(mem_rdata)));
    // R5
    frozen_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));
    // R8
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && mem_ready) |=> (!mem_rd && !mem_wr && done));
    // R4
    wdata_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> $stable(mem_wdata));
endmodule

// File: tb/mar_mdr_bridge_tb.sv
`timescale 1ns/1ps
module mar_mdr_bridge_tb;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_we = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          busy, done, mem_rd, mem_wr, mem_ready;
    logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    logic [DW-1:0] mem [N];
    logic [DW-1:0] ref_mem [N];
    int lat_cur = 1;
    int wait_cnt;
    int acc_cnt;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    mar_mdr_bridge #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model with a programmable latency
    assign mem_ready = (mem_rd || mem_wr) && (wait_cnt == lat_cur - 1);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= 0;
            acc_cnt  <= 0;
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else begin
            if ((mem_rd || mem_wr) && !mem_ready) wait_cnt <= wait_cnt + 1;
            else wait_cnt <= 0;
            if ((mem_rd || mem_wr) && mem_ready) acc_cnt <= acc_cnt + 1;
            if (mem_wr && mem_ready) mem[mem_addr] <= mem_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = 0;
        for (int i = 0; i < N; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(req, bad, 0);
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lat);
        int n;
        int acc0;
        logic [AW-1:0] prev;
        @(negedge clk);
        lat_cur = lat; prev = mem_addr; acc0 = acc_cnt;
        cmd_valid = 1'b1; cmd_we = 1'b1; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_addr = ~a; cmd_wdata = ~d;
        // R4: data register first, address register still old, no write yet
        chk("R4 wdata step1", mem_wdata, d);
        chk("R4 addr step1", mem_addr, prev);
        chk("R4 wr step1", mem_wr, 0);
        chk("R2 busy after accept", busy, 1);
        n = 1;
        forever begin
            @(negedge clk);
            n++;
            if (done || n > 200) break;
            // R5: strobe held, address stable
            chk("R5 wr held", mem_wr, 1);
            chk("R5 addr", mem_addr, a);
        end
        chk("R9 store busy length", n, lat + 2);
        chk("R7 busy at done", busy, 1);
        ref_mem[a] = d;
        chk("R8 one access", acc_cnt, acc0 + 1);
        @(negedge clk);
        chk("R7 done single", done, 0);
        chk("R7 busy low", busy, 0);
        chk_mem("R8 memory contents");
    endtask

    task automatic do_load(input logic [AW-1:0] a, input int lat, input bit spoil);
        int n;
        int acc0;
        @(negedge clk);
        lat_cur = lat; acc0 = acc_cnt;
        cmd_valid = 1'b1; cmd_we = 1'b0; cmd_addr = a; cmd_wdata = 8'h5A;
        @(negedge clk);
        if (spoil) begin
            // R2: a store offered while busy must be ignored
            cmd_valid = 1'b1; cmd_we = 1'b1; cmd_addr = a ^ 1; cmd_wdata = 8'hC3;
        end else begin
            cmd_valid = 1'b0;
        end
        chk("R3 rd after accept", mem_rd, 1);
        chk("R3 addr", mem_addr, a);
        chk("R2 busy after accept", busy, 1);
        n = 1;
        forever begin
            @(negedge clk);
            n++;
            if (done || n > 200) break;
            chk("R5 rd held", mem_rd, 1);
            chk("R5 addr", mem_addr, a);
        end
        cmd_valid = 1'b0;
        chk("R9 load busy length", n, lat + 1);
        chk("R6 load word", rd_data, ref_mem[a]);
        chk("R8 one access", acc_cnt, acc0 + 1);
        @(negedge clk);
        chk("R7 done single", done, 0);
        chk("R7 busy low", busy, 0);
        chk("R6 word held", rd_data, ref_mem[a]);
        if (spoil) begin
            chk("R2 ignored no access", acc_cnt, acc0 + 1);
            chk_mem("R2 ignored no write");
        end
        @(negedge clk);
        chk("R6 word held idle", rd_data, ref_mem[a]);
        chk("R2 no stray busy", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1;
        @(negedge clk);
        // R1: state held at reset values during reset
        chk("R1 busy in reset", busy, 0);
        cmd_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 strobes", {mem_rd, mem_wr}, 0);
        chk("R1 mem_addr", mem_addr, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 mem_wdata", mem_wdata, 0);
        // Sweep of every address with varied latency
        for (int a = 0; a < N; a++)
            do_store(a[AW-1:0], DW'((a * 37 + 11) & 8'hFF), (a % 4) + 1);
        for (int a = 0; a < N; a++)
            do_load(a[AW-1:0], (a % 3) + 1, a[0]);
        for (int a = N - 1; a >= 0; a--) begin
            do_store(a[AW-1:0], DW'(~(a * 19)), 1 + (a % 6));
            do_load(a[AW-1:0], 1 + ((a + 2) % 5), 1'b1);
        end
        do_store(4'h0, 8'hFF, 1);
        do_load(4'h0, 7, 1'b0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule